// File: doc/BRIEF.md
# SHA-512 Compression Core

This block applies the SHA-512 compression function to a single 1024-bit message block. It takes the block together with a 512-bit chaining value and returns the updated chaining value. An `init` input replaces the supplied chaining value with the standard starting hash, which is what the first block of any message uses. Padding, length encoding and sequencing over several blocks stay with the caller. To continue a longer message, the caller feeds each result back as the next block's chaining value.

Inside the block, a message expander keeps a sliding 16-word window and derives the 64-bit schedule words. A round datapath updates the eight 64-bit working variables. Several rounds are chained combinationally within one clock; the default is five, so the 80 rounds take 16 clocks. A small controller sequences the round counter. The caller raises `start` while `ready` is high. Later, `done` pulses for one clock as the registered result appears on `hash_out`.

Top module: `sha512_core`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `hash_out` is all zeros.
- R2: Schedule word 0 is `block_in[1023:960]`, and words 1 to 15 follow in big-endian order, each 64 bits lower. Words 16 to 79 are formed as W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^64. Here s0 is rotr1^rotr8^shr7 and s1 is rotr19^rotr61^shr6.
- R3: Each of the 80 rounds adds its own constant: the low 64 fractional bits of the cube root of the round's prime, counting primes from 2 upward. The message "abc" hashed from the standard start gives ddaf35a1...a54ca49f.
- R4: `hash_out` is the word-wise mod 2^64 sum of the chaining value and the final working variables. Word 0 sits at bits [511:448] of both `hash_in` and `hash_out`.
- R5: When `init` is 1 at start, the standard starting hash 6a09e667f3bcc908... is used, and `hash_in` has no effect on the result.
- R6: A start accepted at clock edge E produces `done` high for exactly one cycle, following edge E+17 (UNROLL=5). `ready` is low from edge E+1 until that same edge.
- R7: `start` while `ready` is low is ignored. It does not alter the block in flight and produces no extra `done`.
- R8: `hash_out` changes only on the edge that raises `done`, and holds its value otherwise.
- R9: Feeding a result back through `hash_in` with `init` 0 continues a multi-block message. A two-block test message gives its published digest 8e959b75...874be909.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin compressing; accepted only while ready is high |
| init | input | 1 | Use the standard starting hash instead of hash_in |
| block_in | input | 1024 | Message block, word 0 in the top bits |
| hash_in | input | 512 | Chaining value, word 0 in the top bits |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle pulse: hash_out has just been updated |
| hash_out | output | 512 | Updated chaining value |

## Verification
The result of each accepted start is due 17 clocks after the accepting edge: one clock to load, 16 clocks of five rounds each, and one clock for the final addition. For each start, the driver records the cycle in which `done` must appear, together with the digest from an independent model in the bench. The monitor samples on falling edges, compares the value and the arrival cycle, and flags any `done` for which nothing is queued. The stimulus covers known digests, chained blocks, all-zero and all-ones words where the additions wrap, back-to-back starts, and `start` held high while a block is in flight.

// File: rtl/sha512_pkg.sv
`timescale 1ns/1ps
package sha512_pkg;
  localparam int WORD_W     = 64;
  localparam int BLK_WORDS  = 16;
  localparam int NUM_VARS   = 8;
  localparam int NUM_ROUNDS = 80;
  localparam int BLOCK_W    = WORD_W * BLK_WORDS;
  localparam int STATE_W    = WORD_W * NUM_VARS;

  typedef logic [WORD_W-1:0] word_t;
  // index 0 holds variable a, index 7 holds variable h
  typedef logic [NUM_VARS-1:0][WORD_W-1:0] vars_t;

  localparam vars_t INIT_HASH = {
    64'h5be0cd19137e2179, 64'h1f83d9abfb41bd6b,
    64'h9b05688c2b3e6c1f, 64'h510e527fade682d1,
    64'ha54ff53a5f1d36f1, 64'h3c6ef372fe94f82b,
    64'hbb67ae8584caa73b, 64'h6a09e667f3bcc908};

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_sig0(word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_sig1(word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t lit_sig0(word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t lit_sig1(word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic vars_t round_step(vars_t v, word_t k, word_t w);
    word_t t1;
    word_t t2;
    vars_t r;
    t1 = v[7] + big_sig1(v[4]) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + k + w;
    t2 = big_sig0(v[0]) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
    r[0] = t1 + t2;
    r[1] = v[0];
    r[2] = v[1];
    r[3] = v[2];
    r[4] = v[3] + t1;
    r[5] = v[4];
    r[6] = v[5];
    r[7] = v[6];
    return r;
  endfunction

  // Round constants: fractional cube-root bits of successive primes,
  // found by bitwise search of floor(cbrt(p * 2^192)).
  function automatic logic [NUM_ROUNDS-1:0][WORD_W-1:0] build_k();
    logic [NUM_ROUNDS-1:0][WORD_W-1:0] tab;
    logic [255:0] tgt;
    logic [255:0] root;
    logic [255:0] cand;
    int found;
    bit is_p;
    tab = '0;
    found = 0;
    for (int n = 2; n < 1000; n++) begin
      if (found < NUM_ROUNDS) begin
        is_p = 1'b1;
        for (int d = 2; d * d <= n; d++) begin
          if (n % d == 0) is_p = 1'b0;
        end
        if (is_p) begin
          tgt  = 256'(n) << 192;
          root = '0;
          for (int b = 66; b >= 0; b--) begin
            cand = root | (256'd1 << b);
            if (cand * cand * cand <= tgt) root = cand;
          end
          tab[found] = root[WORD_W-1:0];
          found++;
        end
      end
    end
    return tab;
  endfunction
endpackage

// File: rtl/sha512_sched.sv
`timescale 1ns/1ps
module sha512_sched
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load,
  input  logic                            step,
  input  logic [BLOCK_W-1:0]              block,
  output logic [UNROLL-1:0][WORD_W-1:0]   lanes
);
  localparam int EXT_N = BLK_WORDS + UNROLL;

  word_t win [BLK_WORDS];
  word_t ext [EXT_N];

  always_comb begin
    for (int i = 0; i < BLK_WORDS; i++) ext[i] = win[i];
    for (int j = 0; j < UNROLL; j++) begin
      ext[BLK_WORDS+j] = lit_sig1(ext[BLK_WORDS-2+j]) + ext[BLK_WORDS-7+j]
                       + lit_sig0(ext[j+1]) + ext[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BLK_WORDS; i++) win[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < BLK_WORDS; i++)
        win[i] <= block[BLOCK_W-1-WORD_W*i -: WORD_W];
    end else if (step) begin
      for (int i = 0; i < BLK_WORDS; i++) win[i] <= ext[i+UNROLL];
    end
  end

  always_comb begin
    for (int u = 0; u < UNROLL; u++) lanes[u] = win[u];
  end

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> lanes[0] == $past(block[BLOCK_W-1 -: WORD_W]));
endmodule

// File: rtl/sha512_rounds.sv
`timescale 1ns/1ps
module sha512_rounds
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5,
  parameter int CW     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          step,
  input  logic [CW-1:0]                 cnt,
  input  vars_t                         seed,
  input  logic [UNROLL-1:0][WORD_W-1:0] lanes,
  output vars_t                         vars
);
  localparam int IW = $clog2(NUM_ROUNDS);
  localparam logic [NUM_ROUNDS-1:0][WORD_W-1:0] KROM = build_k();

  vars_t chain [UNROLL+1];
  assign chain[0] = vars;

  for (genvar u = 0; u < UNROLL; u++) begin : g_lane
    logic [IW-1:0] kidx;
    word_t         kval;
    assign kidx = IW'(int'(cnt) * UNROLL + u);
    assign kval = (int'(kidx) < NUM_ROUNDS) ? KROM[kidx] : '0;
    assign chain[u+1] = round_step(chain[u], kval, lanes[u]);
  end

  always_ff @(posedge clk) begin
    if (rst)       vars <= '0;
    else if (load) vars <= seed;
    else if (step) vars <= chain[UNROLL];
  end

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> vars == $past(seed));
endmodule

// File: rtl/sha512_ctrl.sv
`timescale 1ns/1ps
module sha512_ctrl #(
  parameter int NCYC = 16,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          ready,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic [CW-1:0] cnt
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t state;

  assign ready  = (state == S_IDLE);
  assign load   = start && ready && !rst;
  assign step   = (state == S_RUN);
  assign finish = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (load) begin
          state <= S_RUN;
          cnt   <= '0;
        end
        S_RUN: begin
          if (cnt == CW'(NCYC-1)) state <= S_FIN;
          else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !ready && cnt == '0);
  // R6
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> ready && !finish);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && step && cnt != CW'(NCYC-1)) |=> step && cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/sha512_core.sv
`timescale 1ns/1ps
module sha512_core
  import sha512_pkg::*;
#(
  parameter int UNROLL = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               init,
  input  logic [BLOCK_W-1:0] block_in,
  input  logic [STATE_W-1:0] hash_in,
  output logic               ready,
  output logic               done,
  output logic [STATE_W-1:0] hash_out
);
  localparam int NCYC = NUM_ROUNDS / UNROLL;
  localparam int CW   = (NCYC > 1) ? $clog2(NCYC) : 1;

  logic                          load;
  logic                          step;
  logic                          finish;
  logic [CW-1:0]                 cnt;
  logic [UNROLL-1:0][WORD_W-1:0] lanes;
  vars_t                         seed;
  vars_t                         hsave;
  vars_t                         vars;

  always_comb begin
    for (int i = 0; i < NUM_VARS; i++)
      seed[i] = init ? INIT_HASH[i] : hash_in[STATE_W-1-WORD_W*i -: WORD_W];
  end

  sha512_ctrl #(.NCYC(NCYC), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .load(load), .step(step), .finish(finish), .cnt(cnt));

  sha512_sched #(.UNROLL(UNROLL)) u_sched (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .block(block_in), .lanes(lanes));

  sha512_rounds #(.UNROLL(UNROLL), .CW(CW)) u_rounds (
    .clk(clk), .rst(rst), .load(load), .step(step), .cnt(cnt),
    .seed(seed), .lanes(lanes), .vars(vars));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsave    <= '0;
      hash_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (load) hsave <= seed;
      if (finish) begin
        for (int i = 0; i < NUM_VARS; i++)
          hash_out[STATE_W-1-WORD_W*i -: WORD_W] <= hsave[i] + vars[i];
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hash_out) |-> done);
  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);
endmodule

// File: tb/test_sha512_core.sv
`timescale 1ns/1ps
module test_sha512_core;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          init = 1'b0;
  logic [1023:0] block_in = '0;
  logic [511:0]  hash_in = '0;
  logic          ready;
  logic          done;
  logic [511:0]  hash_out;

  always #2 clk = ~clk;

  sha512_core i_sha512_core (
    .clk(clk), .rst(rst), .start(start), .init(init),
    .block_in(block_in), .hash_in(hash_in),
    .ready(ready), .done(done), .hash_out(hash_out));

  localparam int LAT = 17;
  localparam logic [511:0] IV = {
    64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
    64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};
  localparam logic [511:0] ABC_DIG = {
    64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2, 64'h0a9eeee64b55d39a,
    64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd, 64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};
  localparam logic [511:0] TWO_DIG = {
    64'h8e959b75dae313da, 64'h8cf4f72814fc143f, 64'h8f7779c6eb9f7fa1, 64'h7299aeadb6889018,
    64'h501d289e4900f7e4, 64'h331b99dec4b5433a, 64'hc7d329eeb6dd2654, 64'h5e96e55b874be909};

  typedef struct packed {
    logic [511:0] h;
    int           due;
    logic [63:0]  tag;
  } exp_t;

  exp_t         q[$];
  exp_t         e;
  int           cyc = 0;
  int           checks = 0;
  int           errors = 0;
  logic         mon_on = 1'b0;
  logic [511:0] last_out = '0;
  logic [63:0]  kt [80];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] kval(int idx);
    int seen;
    logic [255:0] r, c, t;
    seen = -1;
    r = '0;
    for (int n = 2; n < 1000; n++) begin
      bit pr;
      pr = 1'b1;
      for (int d = 2; d < n; d++) if (n % d == 0) pr = 1'b0;
      if (pr && seen < idx) begin
        seen++;
        if (seen == idx) begin
          t = 256'(n) << 192;
          for (int b = 70; b >= 0; b--) begin
            c = r + (256'd1 << b);
            if (c * c * c <= t) r = c;
          end
        end
      end
    end
    return r[63:0];
  endfunction

  function automatic logic [511:0] ref_comp(logic [1023:0] b, logic [511:0] h);
    logic [63:0] w [80];
    logic [63:0] v [8];
    logic [63:0] t1, t2;
    logic [511:0] res;
    for (int t = 0; t < 16; t++) w[t] = b[1023-64*t -: 64];
    for (int t = 16; t < 80; t++)
      w[t] = (rr(w[t-2], 19) ^ rr(w[t-2], 61) ^ (w[t-2] >> 6)) + w[t-7]
           + (rr(w[t-15], 1) ^ rr(w[t-15], 8) ^ (w[t-15] >> 7)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = h[511-64*i -: 64];
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + (rr(v[4], 14) ^ rr(v[4], 18) ^ rr(v[4], 41))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
      t2 = (rr(v[0], 28) ^ rr(v[0], 34) ^ rr(v[0], 39))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[511-64*i -: 64] = h[511-64*i -: 64] + v[i];
    return res;
  endfunction

  function automatic logic [1023:0] rnd_block();
    logic [1023:0] b;
    for (int i = 0; i < 32; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  function automatic logic [511:0] rnd_hash();
    logic [511:0] h;
    for (int i = 0; i < 16; i++) h[32*i +: 32] = $urandom;
    return h;
  endfunction

  // driver: waits for ready, pulses start, queues the expected result
  task automatic send(input logic [1023:0] b, input logic [511:0] h, input bit ini,
                      input logic [511:0] expv, input logic [63:0] tag);
    exp_t x;
    @(negedge clk);
    while (!ready) @(negedge clk);
    block_in = b;
    hash_in  = h;
    init     = ini;
    start    = 1'b1;
    x.h   = expv;
    x.due = cyc + 1 + LAT;
    x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "done with nothing pending", 512'(done), 512'(0));
        end else begin
          e = q.pop_front();
          check(hash_out == e.h, string'(e.tag), "digest", hash_out, e.h);
          check(cyc == e.due, "R6", "done arrival cycle", 512'(cyc), 512'(e.due));
          check(ready == 1'b1, "R6", "ready with done", 512'(ready), 512'(1));
        end
        last_out <= hash_out;
      end else if (hash_out != last_out) begin
        check(1'b0, "R8", "hash_out moved without done", hash_out, last_out);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1023:0] b1, b2, bx;
    logic [511:0]  hx, mid;
    for (int i = 0; i < 80; i++) kt[i] = kval(i);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(ready == 1'b1, "R1", "ready after reset", 512'(ready), 512'(1));
    check(done == 1'b0, "R1", "done after reset", 512'(done), 512'(0));
    check(hash_out == '0, "R1", "hash_out after reset", hash_out, '0);
    mon_on = 1'b1;

    // R3 R5: "abc" from the standard start, hash_in is noise
    bx = '0;
    bx[1023:992] = 32'h61626380;
    bx[7:0] = 8'h18;
    send(bx, rnd_hash(), 1'b1, ABC_DIG, "R3");
    drain();
    // R8: the digest stays put while idle
    repeat (10) @(negedge clk);
    check(hash_out == ABC_DIG, "R8", "held while idle", hash_out, ABC_DIG);

    // R9: two-block message, second block chained through hash_in
    b1 = '0;
    for (int k = 0; k < 112; k++) b1[1023-8*k -: 8] = 8'(8'h61 + k / 8 + k % 8);
    b1[1023-8*112 -: 8] = 8'h80;
    b2 = '0;
    b2[127:0] = 128'd896;
    mid = ref_comp(b1, IV);
    send(b1, '0, 1'b1, mid, "R9");
    send(b2, mid, 1'b0, TWO_DIG, "R9");
    drain();

    // R2 R4: random blocks and chaining values, issued back to back
    for (int n = 0; n < 4; n++) begin
      bx = rnd_block();
      hx = rnd_hash();
      send(bx, hx, 1'b0, ref_comp(bx, hx), "R4");
    end
    drain();

    // R5: init overrides a random hash_in
    bx = rnd_block();
    send(bx, rnd_hash(), 1'b1, ref_comp(bx, IV), "R5");
    // R2 R4: extremes where the additions wrap
    send('0, '0, 1'b0, ref_comp('0, '0), "R2");
    send('1, '1, 1'b0, ref_comp('1, '1), "R4");
    drain();

    // R7: start held high with other inputs while busy
    bx = rnd_block();
    hx = rnd_hash();
    send(bx, hx, 1'b0, ref_comp(bx, hx), "R7");
    @(negedge clk);
    block_in = rnd_block();
    hash_in  = rnd_hash();
    init     = 1'b1;
    start    = 1'b1;
    repeat (8) @(negedge clk);
    start = 1'b0;
    drain();
    repeat (30) @(negedge clk);
    check(q.size() == 0, "R7", "no extra result", 512'(q.size()), 512'(0));
    check(ready == 1'b1, "R7", "idle after busy start", 512'(ready), 512'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule